// File: doc/BRIEF.md
# Programmable SPI Master Shift Channel

This block is one SPI master channel. It turns parallel words into serial frames on a clock line, a data-out line and a chip-select line, and it collects the data-in line into words at the same time. The host side writes words into a one-deep transmit holding register and takes results from a one-deep receive holding register. Both registers are valid/ready streams. A set of plain control pins selects clock polarity, sampling phase, a power-of-two clock divider, the word length, the chip-select level and the transfer direction.

The serial clock period is `2^(clk_exp+1)` cycles of `clk`. Treating half the `clk` rate as the reference, the serial clock is that reference divided by `2^clk_exp`, and `clk_exp` runs from 0 to 15.

Chip select is not tied to the shifting. It follows a software-forced control bit, so one select window can span any number of words.

The three transfer directions are:
- **Full duplex:** each word needs a transmit word and a free receive register.
- **Transmit-only:** words run back to back and received bits are dropped.
- **Receive-only:** the first word is started by a dummy transmit word. After that, every receive read launches the next word, reusing the dummy. Switching to full duplex before the last read stops the chain.

Back-pressure rules:
- `tx_ready` is high exactly when the transmit register is empty. A word is taken on a clock edge where `tx_valid && tx_ready`.
- `rx_valid` is high exactly when a received word is waiting. It stays high, with `rx_data` unchanged, until a clock edge with `rx_ready` high.
- While `rx_valid` is high, full-duplex and receive-only modes start no new word.

The configuration inputs must only change while no word is shifting.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset `tx_ready` is 1, `rx_valid` is 0 and `eot` is 0. `sclk` equals `cpol`, and `cs_o` is 1.
- R2: While a word shifts, each half period of `sclk` lasts exactly `2^clk_exp` clock cycles. A word of N bits produces exactly 2N `sclk` edges.
- R3: A word has `wlen_m1+1` bits, from 4 to 32, and goes out most-significant bit first. Transmit bits above the word length are ignored. The received word is right-aligned in `rx_data`, and its upper bits are 0.
- R4: `cpol` sets the idle level of `sclk`. With `cpha`=0, data-in is sampled on leading edges and data-out changes on trailing edges. With `cpha`=1 the two roles swap. All four combinations transfer correctly.
- R5: One cycle after the inputs, `cs_o` equals `cs_force XOR cs_active_low`. So with `cs_active_low`=1, forcing drives `cs_o` to 0.
- R6: In full duplex (`xfer_mode`=00, and 11 behaves the same), a word starts only when a transmit word is held and the receive register is empty. A held received word is kept unchanged until it is read.
- R7: In transmit-only mode (`xfer_mode`=10), held words shift back to back, and `rx_valid` never rises.
- R8: In receive-only mode (`xfer_mode`=01), a held dummy word starts the first word. Each receive read launches one more word that resends the dummy. A read made after switching to full duplex launches nothing.
- R9: `tx_ready` shows the transmit register empty and `rx_valid` shows the receive register full. `eot` clears when a word starts and sets when it completes with the shifter idle.
- R10: While `chan_en` is 0 a written transmit word is held and not shifted. Dropping `chan_en` mid-word aborts the word, which is not delivered, and returns `sclk` to `cpol` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low holds and aborts shifting |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| clk_exp | input | 4 | Divider exponent; half period = 2^clk_exp cycles |
| wlen_m1 | input | 5 | Word length minus one (3 to 31) |
| cs_active_low | input | 1 | 1: chip select asserted low; 0: asserted high |
| cs_force | input | 1 | Assert chip select |
| xfer_mode | input | 2 | 00 duplex, 01 receive-only, 10 transmit-only |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word waiting |
| rx_ready | input | 1 | Host takes the received word |
| rx_data | output | 32 | Received word, right-aligned, upper bits zero |
| eot | output | 1 | Last word finished and shifter idle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
- **Sweep of modes and lengths.** Every clock mode is run against word lengths of 4, 5, 8, 12, 16, 31 and 32. The transmit words carry set bits above the word length, so truncation, bit order and sampling-edge errors each show up as a distinct wrong value on one side.
- **Divider exponents.** Exponents 0 to 3 are timed edge by edge. This separates a wrong divider from a wrong edge count.
- **Direction modes.** Directed sequences cover a two-word burst against a full receive register, three back-to-back transmit-only words, and a receive-only chain ended by a mode switch. They tell apart the start conditions of the three directions.
- **Disable.** A write made while disabled, and an abort in the middle of a word, show that the enable gates starting and shifting without losing the held word.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'b00,
    MODE_RX_ONLY = 2'b01,
    MODE_TX_ONLY = 2'b10,
    MODE_RSVD    = 2'b11
  } xfer_mode_e;

endpackage

// File: rtl/spi_half_tick.sv
// Half-period timer: pulses once every 2^exp_sel cycles while run is high.
module spi_half_tick #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(exp_sel));
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
// Edge sequencer and data shifters for one word.
module spi_shift_core #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [LEN_W-1:0]  wlen_m1,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              running,
  output logic              done,
  output logic              sclk_q,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EDGE_W = LEN_W + 1;
  localparam int TOPB   = DATA_W - 1;

  logic              busy_q, fin_q, pha_q;
  logic [LEN_W-1:0]  len_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              sample_now, shift_now, last_edge;

  assign sample_now = tick && (edge_q[0] == pha_q);
  assign shift_now  = tick && (edge_q[0] != pha_q) && (edge_q != '0);
  assign last_edge  = tick && (edge_q == {len_q, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      pha_q  <= 1'b0;
      sclk_q <= 1'b0;
      len_q  <= '0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
      sclk_q <= cpol;
      pha_q  <= cpha;
      len_q  <= wlen_m1;
      edge_q <= '0;
      tx_sh  <= tx_word << (TOPB - int'(wlen_m1));
      rx_sh  <= '0;
    end else if (fin_q) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], miso};
      if (shift_now)  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (last_edge)  fin_q <= 1'b1;
    end
  end

  assign busy    = busy_q;
  assign running = busy_q && !fin_q;
  assign done    = fin_q;
  assign mosi    = busy_q & tx_sh[DATA_W-1];
  assign rx_word = rx_sh;
endmodule

// File: rtl/spi_hold_ctrl.sv
// Transmit/receive holding registers, start rules per direction, end flag.
module spi_hold_ctrl
  import spi_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  xfer_mode_e        mode,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              start,
  output logic [DATA_W-1:0] word_out,
  output logic              eot
);
  logic              tx_full, rx_full, rearm, eot_q;
  logic [DATA_W-1:0] tx_hold, rx_hold;
  xfer_mode_e        mode_l;
  logic              want, tx_acc, rx_take;

  always_comb begin
    case (mode)
      MODE_TX_ONLY: want = tx_full;
      MODE_RX_ONLY: want = (tx_full || rearm) && !rx_full;
      default:      want = tx_full && !rx_full;
    endcase
  end

  assign start   = chan_en && !busy && want;
  assign tx_acc  = tx_valid && !tx_full;
  assign rx_take = rx_full && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
      rx_full <= 1'b0;
      rx_hold <= '0;
      rearm   <= 1'b0;
      eot_q   <= 1'b0;
      mode_l  <= MODE_DUPLEX;
    end else begin
      if (start && tx_full)  tx_full <= 1'b0;
      else if (tx_acc)       tx_full <= 1'b1;
      if (tx_acc)            tx_hold <= tx_data;

      if (done && mode_l != MODE_TX_ONLY) begin
        rx_full <= 1'b1;
        rx_hold <= rx_word;
      end else if (rx_take) begin
        rx_full <= 1'b0;
      end

      if (!chan_en || mode != MODE_RX_ONLY) rearm <= 1'b0;
      else if (start)                       rearm <= 1'b0;
      else if (rx_take)                     rearm <= 1'b1;

      if (start)      eot_q <= 1'b0;
      else if (done)  eot_q <= 1'b1;

      if (start)      mode_l <= mode;
    end
  end

  assign tx_ready = !tx_full;
  assign rx_valid = rx_full;
  assign rx_data  = rx_hold;
  assign word_out = tx_hold;
  assign eot      = eot_q;
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
  import spi_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [EXP_W-1:0]  clk_exp,
  input  logic [LEN_W-1:0]  wlen_m1,
  input  logic              cs_active_low,
  input  logic              cs_force,
  input  logic [1:0]        xfer_mode,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              eot,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_o
);
  xfer_mode_e        mode_e;
  logic              tick, running, busy, done, start, sclk_q;
  logic [DATA_W-1:0] word_out, rx_word;
  logic              cs_q;

  assign mode_e = xfer_mode_e'(xfer_mode);

  spi_half_tick #(.EXP_W(EXP_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(running), .exp_sel(clk_exp), .tick(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(~chan_en), .tick(tick),
    .cpol(cpol), .cpha(cpha), .wlen_m1(wlen_m1), .tx_word(word_out),
    .miso(miso), .busy(busy), .running(running), .done(done),
    .sclk_q(sclk_q), .mosi(mosi), .rx_word(rx_word)
  );

  spi_hold_ctrl #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode(mode_e),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .done(done), .rx_word(rx_word), .start(start),
    .word_out(word_out), .eot(eot)
  );

  // chip select: registered, asserted level set by cs_active_low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_force ^ cs_active_low;
  end

  assign cs_o = cs_q;
  assign sclk = busy ? sclk_q : cpol;
endmodule

// File: rtl/spi_chan_engine_chk.sv
module spi_chan_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              cpol,
  input logic              cs_active_low,
  input logic              cs_force,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              eot,
  input logic              sclk,
  input logic              cs_o
);
  assert_cs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_o == $past(cs_force ^ cs_active_low)));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (sclk == cpol));

  assert_tx_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_eot_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (sclk == cpol));
endmodule

bind spi_chan_engine spi_chan_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cpol(cpol),
  .cs_active_low(cs_active_low), .cs_force(cs_force),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .eot(eot), .sclk(sclk), .cs_o(cs_o)
);

// File: tb/spi_chan_engine_tb.sv
`timescale 1ns/1ps
module spi_chan_engine_tb;
  logic clk = 0, rst_n = 0;
  logic chan_en = 1, cpol = 0, cpha = 0, cs_active_low = 1, cs_force = 0;
  logic [3:0] clk_exp = 0;
  logic [4:0] wlen_m1 = 5'd7;
  logic [1:0] xfer_mode = 2'b00;
  logic tx_valid = 0, rx_ready = 0, miso;
  logic [31:0] tx_data = 0;
  logic tx_ready, rx_valid, eot, sclk, mosi, cs_o;
  logic [31:0] rx_data;

  always #10 clk = ~clk;

  spi_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cpol(cpol), .cpha(cpha),
    .clk_exp(clk_exp), .wlen_m1(wlen_m1), .cs_active_low(cs_active_low),
    .cs_force(cs_force), .xfer_mode(xfer_mode), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .eot(eot), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // slave model
  int nb = 8;
  logic [31:0] sl_tx [8];
  logic [31:0] sl_rx [8];
  int sl_cnt = 0, e_cnt = 0;
  time t_edge [4];
  logic cs_act;
  assign cs_act = cs_o ^ cs_active_low;

  always @(sclk) begin
    if (cs_act) begin
      if (e_cnt < 4) t_edge[e_cnt] = $time;
      e_cnt++;
      if ((sclk != cpol) ^ cpha) begin
        if (sl_cnt / nb < 8)
          sl_rx[sl_cnt/nb] = {sl_rx[sl_cnt/nb][30:0], mosi};
        sl_cnt++;
      end
    end
  end

  always @* begin
    if (sl_cnt / nb < 8) miso = sl_tx[sl_cnt/nb][nb-1-(sl_cnt%nb)];
    else                 miso = 1'b0;
  end

  function automatic logic [31:0] msk(int n);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slave_reset();
    sl_cnt = 0;
    e_cnt  = 0;
    for (int i = 0; i < 8; i++) sl_rx[i] = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(logic [31:0] d);
    @(negedge clk);
    tx_valid = 1;
    tx_data  = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    int g = 0;
    @(negedge clk);
    while (!rx_valid && g < 100000) begin
      @(negedge clk);
      g++;
    end
    d = rx_data;
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic setup(logic pol, logic pha, int bits, logic [1:0] md, logic [3:0] ex);
    @(negedge clk);
    cs_force = 0;
    cpol = pol; cpha = pha; nb = bits;
    wlen_m1 = 5'(bits - 1); xfer_mode = md; clk_exp = ex;
    cyc(2);
    slave_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  int wls [7] = '{4, 5, 8, 12, 16, 31, 32};

  initial begin
    logic [31:0] d, tw;
    int ec;
    for (int i = 0; i < 8; i++) begin sl_tx[i] = 0; sl_rx[i] = 0; end
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 tx_ready", 32'(tx_ready), 1);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 eot", 32'(eot), 0);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 cs_o", 32'(cs_o), 1);

    // R5 chip-select level
    cs_force = 1; cyc(1);
    chk("R5 force low-active", 32'(cs_o), 0);
    cs_active_low = 0; cyc(1);
    chk("R5 force high-active", 32'(cs_o), 1);
    cs_force = 0; cyc(1);
    chk("R5 release high-active", 32'(cs_o), 0);
    cs_active_low = 1; cyc(1);
    chk("R5 release low-active", 32'(cs_o), 1);

    // R3/R4/R6 sweep over modes and lengths
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 7; k++) begin
        setup(m[1], m[0], wls[k], 2'b00, 4'd0);
        sl_tx[0] = 32'h6B1D_E2F7 ^ (m * 32'h0101_0101) ^ (k * 32'h1111);
        tw = 32'hC3A5_9E17 + m * 32'h0001_0203 + k * 32'h77;
        cs_force = 1; cyc(2);
        push_tx(tw);
        pop_rx(d);
        chk($sformatf("R3 R4 rx mode%0d len%0d", m, wls[k]), d, sl_tx[0] & msk(wls[k]));
        chk($sformatf("R3 R4 mosi mode%0d len%0d", m, wls[k]), sl_rx[0], tw & msk(wls[k]));
        chk("R9 eot after word", 32'(eot), 1);
      end
    end

    // R2 divider timing
    for (int e = 0; e < 4; e++) begin
      setup(0, 0, 8, 2'b00, 4'(e));
      sl_tx[0] = 32'h5D;
      cs_force = 1; cyc(2);
      push_tx(32'h3B);
      pop_rx(d);
      chk($sformatf("R2 half period exp%0d", e), 32'(t_edge[1] - t_edge[0]), 32'(20 * (1 << e)));
      chk($sformatf("R2 half period2 exp%0d", e), 32'(t_edge[3] - t_edge[2]), 32'(20 * (1 << e)));
      chk($sformatf("R2 edge count exp%0d", e), 32'(e_cnt), 16);
    end

    // R6 back-pressure in duplex
    setup(0, 0, 8, 2'b00, 4'd0);
    sl_tx[0] = 32'h3C; sl_tx[1] = 32'hA7;
    cs_force = 1; cyc(2);
    push_tx(32'h11);
    push_tx(32'h22);
    cyc(100);
    chk("R6 rx held valid", 32'(rx_valid), 1);
    chk("R6 rx held data", rx_data, 32'h3C);
    chk("R6 second word waits", 32'(sl_cnt), 8);
    chk("R9 tx still full", 32'(tx_ready), 0);
    pop_rx(d);
    pop_rx(d);
    chk("R6 second word rx", d, 32'hA7);
    chk("R6 second word mosi", sl_rx[1], 32'h22);

    // R7 transmit-only
    setup(0, 1, 8, 2'b10, 4'd0);
    cs_force = 1; cyc(2);
    push_tx(32'h5A); push_tx(32'h0F); push_tx(32'hE1);
    cyc(150);
    chk("R7 no rx", 32'(rx_valid), 0);
    chk("R7 word0", sl_rx[0], 32'h5A);
    chk("R7 word1", sl_rx[1], 32'h0F);
    chk("R7 word2", sl_rx[2], 32'hE1);
    chk("R9 eot tx-only", 32'(eot), 1);
    chk("R9 tx empty", 32'(tx_ready), 1);

    // R8 receive-only chain
    setup(1, 0, 8, 2'b01, 4'd0);
    sl_tx[0] = 32'h81; sl_tx[1] = 32'h42; sl_tx[2] = 32'h24; sl_tx[3] = 32'h18;
    cs_force = 1; cyc(2);
    push_tx(32'hFF);
    cyc(60);
    chk("R8 one word until read", 32'(sl_cnt), 8);
    chk("R8 dummy consumed", 32'(tx_ready), 1);
    pop_rx(d);
    chk("R8 word0", d, 32'h81);
    cyc(60);
    chk("R8 read launched word1", 32'(sl_cnt), 16);
    pop_rx(d);
    chk("R8 word1", d, 32'h42);
    cyc(60);
    xfer_mode = 2'b00;
    pop_rx(d);
    chk("R8 word2", d, 32'h24);
    cyc(60);
    chk("R8 no extra word", 32'(sl_cnt), 24);
    chk("R8 rx empty", 32'(rx_valid), 0);
    chk("R8 dummy resent", sl_rx[1], 32'hFF);

    // R10 disabled channel holds the write
    setup(0, 0, 8, 2'b00, 4'd0);
    chan_en = 0;
    sl_tx[0] = 32'h99;
    cs_force = 1; cyc(2);
    push_tx(32'h6E);
    cyc(50);
    chk("R10 no edges while disabled", 32'(e_cnt), 0);
    chk("R10 write held", 32'(tx_ready), 0);
    chan_en = 1;
    pop_rx(d);
    chk("R10 held word rx", d, 32'h99);
    chk("R10 held word mosi", sl_rx[0], 32'h6E);

    // R10 abort mid-word
    setup(1, 0, 32, 2'b00, 4'd3);
    cs_force = 1; cyc(2);
    push_tx(32'hDEAD_BEEF);
    cyc(40);
    chk("R9 eot low mid-word", 32'(eot), 0);
    chan_en = 0;
    cyc(1);
    chk("R10 sclk idle after abort", 32'(sclk), 1);
    cyc(100);
    ec = e_cnt;
    chk("R10 aborted word not delivered", 32'(rx_valid), 0);
    chan_en = 1;
    cyc(100);
    chk("R10 no restart", 32'(e_cnt), 32'(ec));
    chk("R10 tx empty after abort", 32'(tx_ready), 1);

    cs_force = 0;
    cyc(2);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule